// File: doc/BRIEF.md
# Clock, Reset and Sleep Sequencer

This block sits between the raw oscillator of a small 8-bit controller and the rest of the chip. It divides the oscillator by two into an internal phase clock and counts oscillator periods into twelve-period machine cycles. It also turns a noisy external reset pin into a clean, qualified core reset and decides which parts of the chip get a clock at any moment.

Software selects one of two sleep depths through two write strobes. In the light sleep (idle) only the processor clock is gated. Peripherals and the oscillator keep running, and any interrupt request whose enable is set brings the processor back on a machine-cycle boundary. In the deep sleep (power-down) the block asks the oscillator to stop and gates every clock. Interrupts are then ignored, and only a qualified reset returns the chip to normal running. The external-access strap is copied while the core reset is active and is frozen otherwise.

Top module: `pwr_seq_ctrl`

## Requirements
- R1: `phase_clk` is 0 while `core_rst` is high. Outside reset it changes level on every oscillator period, so it runs at half the oscillator rate.
- R2: `core_rst` is raised only if `rst_pin` has been sampled high on at least 24 consecutive oscillator edges (two machine cycles of 12 periods each). A run of 23 does not raise it, and a single low sample restarts the count.
- R3: When a qualified reset is released, `core_rst` is still high after the second oscillator edge that samples `rst_pin` low and is low after the third.
- R4: A pulse on `idle_wr` in normal running clears `cpu_clk_en` from the next oscillator period. `per_clk_en` and `osc_run` stay high.
- R5: In idle, a request bit set together with its enable bit in `irq_req`/`irq_en` raises `cpu_clk_en` again within 12 oscillator periods. The exit lands on a machine-cycle boundary, so the gap between two idle exits with no reset between them is a whole multiple of 12 periods.
- R6: In idle, a request with no matching enable bit (masked, or enable without request) leaves `cpu_clk_en` low.
- R7: A pulse on `pd_wr` in normal running drives `osc_run`, `per_clk_en` and `cpu_clk_en` low from the next period. Enabled interrupts then leave all three low.
- R8: If `idle_wr` and `pd_wr` pulse in the same cycle, power-down is entered.
- R9: A qualified reset ends both idle and power-down and leaves all three enables high after release. `osc_run` follows `rst_pin` high at once, so the oscillator runs while the reset is being qualified.
- R10: `ea_latched` takes the value of `ea_strap` while `core_rst` is high and holds it while `core_rst` is low.
- R11: An enabled request that is already pending when idle is entered causes an exit within 12 periods of entry.
- R12: A `pd_wr` pulse while in idle is ignored, so `osc_run` stays high.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| osc_clk | input | 1 | Raw oscillator clock |
| rst_pin | input | 1 | External reset pin, asynchronous, active high |
| ea_strap | input | 1 | External-access strap level |
| irq_req | input | IRQ_W | Interrupt request lines |
| irq_en | input | IRQ_W | Per-line interrupt enables |
| idle_wr | input | 1 | Write strobe setting the idle bit |
| pd_wr | input | 1 | Write strobe setting the power-down bit |
| phase_clk | output | 1 | Oscillator divided by two |
| core_rst | output | 1 | Qualified core reset |
| cpu_clk_en | output | 1 | Processor clock enable |
| per_clk_en | output | 1 | Peripheral clock enable |
| osc_run | output | 1 | Request to keep the oscillator running |
| ea_latched | output | 1 | Strap level captured during reset |

## Verification
Two functions can fall in the same oscillator cycle: an enabled interrupt wakes from idle, and the idle entry itself happens. The bench provokes this by raising a request and its enable before the idle write. A correct design must still drop the processor clock and then restore it within one machine cycle. The two sleep strobes are also pulsed in the same cycle, and the bench judges the result by the oscillator request and the peripheral enable dropping together. Random reset pulse lengths and random request/enable patterns are compared against bench functions that decide from the requirements whether a reset or a wake is due.

// File: rtl/pwr_seq_pkg.sv
`timescale 1ns/1ps
package pwr_seq_pkg;

  typedef enum logic [1:0] {
    PM_RUN  = 2'd0,
    PM_IDLE = 2'd1,
    PM_DOWN = 2'd2
  } pmode_e;

  // Number of oscillator edges the reset pin must stay high.
  function automatic int unsigned qual_periods(input int unsigned per_mc,
                                               input int unsigned n_mc);
    return per_mc * n_mc;
  endfunction

  // Mode transition rule; deep sleep wins over light sleep.
  function automatic pmode_e next_mode(input pmode_e cur,
                                       input logic   idle_set,
                                       input logic   down_set,
                                       input logic   wake,
                                       input logic   mc_edge);
    pmode_e nxt;
    nxt = cur;
    case (cur)
      PM_RUN: begin
        if (down_set)      nxt = PM_DOWN;
        else if (idle_set) nxt = PM_IDLE;
      end
      PM_IDLE: if (wake && mc_edge) nxt = PM_RUN;
      PM_DOWN: nxt = PM_DOWN;
      default: nxt = PM_RUN;
    endcase
    return nxt;
  endfunction

endpackage

// File: rtl/rst_qualifier.sv
`timescale 1ns/1ps
module rst_qualifier #(
  parameter int unsigned QUAL = 24
) (
  input  logic clk,
  input  logic rst_pin,
  output logic core_rst
);
  localparam int unsigned CW = $clog2(QUAL + 1);

  logic          sync_a;
  logic          sync_b;
  logic [CW-1:0] hi_cnt;

  always_ff @(posedge clk) begin
    sync_a <= rst_pin;
    sync_b <= sync_a;
  end

  // Saturating run-length counter of synchronised high samples.
  always_ff @(posedge clk) begin
    if (!sync_b)                  hi_cnt <= '0;
    else if (hi_cnt != CW'(QUAL)) hi_cnt <= hi_cnt + 1'b1;
  end

  assign core_rst = (hi_cnt == CW'(QUAL));
endmodule

// File: rtl/osc_divider.sv
`timescale 1ns/1ps
module osc_divider #(
  parameter int unsigned MC_PERIODS = 12
) (
  input  logic clk,
  input  logic rst,
  output logic phase_clk,
  output logic mc_last
);
  localparam int unsigned MW = $clog2(MC_PERIODS);

  logic [MW-1:0] mc_cnt;

  always_ff @(posedge clk) begin
    if (rst) begin
      phase_clk <= 1'b0;
      mc_cnt    <= '0;
    end else begin
      phase_clk <= ~phase_clk;
      mc_cnt    <= mc_last ? '0 : mc_cnt + 1'b1;
    end
  end

  assign mc_last = (mc_cnt == MW'(MC_PERIODS - 1));
endmodule

// File: rtl/mode_fsm.sv
`timescale 1ns/1ps
module mode_fsm
  import pwr_seq_pkg::*;
#(
  parameter int unsigned IRQ_W = 4
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             idle_wr,
  input  logic             pd_wr,
  input  logic [IRQ_W-1:0] irq_req,
  input  logic [IRQ_W-1:0] irq_en,
  input  logic             mc_last,
  output pmode_e           mode,
  output logic             enter_pd,
  output logic             wake_exit
);
  logic [IRQ_W-1:0] armed_lines;
  logic             wake_now;
  logic             wake_hold;
  logic             wake_any;
  pmode_e           mode_nxt;

  for (genvar i = 0; i < IRQ_W; i++) begin : g_line
    assign armed_lines[i] = irq_req[i] & irq_en[i];
  end

  assign wake_now = |armed_lines;
  assign wake_any = wake_now | wake_hold;
  assign mode_nxt = next_mode(mode, idle_wr, pd_wr, wake_any, mc_last);

  assign enter_pd  = (mode == PM_RUN)  && (mode_nxt == PM_DOWN);
  assign wake_exit = (mode == PM_IDLE) && (mode_nxt == PM_RUN);

  always_ff @(posedge clk) begin
    if (rst) begin
      mode      <= PM_RUN;
      wake_hold <= 1'b0;
    end else begin
      mode      <= mode_nxt;
      wake_hold <= (mode == PM_IDLE) && wake_any && !wake_exit;
    end
  end
endmodule

// File: rtl/pwr_seq_ctrl.sv
`timescale 1ns/1ps
module pwr_seq_ctrl
  import pwr_seq_pkg::*;
#(
  parameter int unsigned IRQ_W      = 4,
  parameter int unsigned MC_PERIODS = 12,
  parameter int unsigned RST_MCS    = 2
) (
  input  logic             osc_clk,
  input  logic             rst_pin,
  input  logic             ea_strap,
  input  logic [IRQ_W-1:0] irq_req,
  input  logic [IRQ_W-1:0] irq_en,
  input  logic             idle_wr,
  input  logic             pd_wr,
  output logic             phase_clk,
  output logic             core_rst,
  output logic             cpu_clk_en,
  output logic             per_clk_en,
  output logic             osc_run,
  output logic             ea_latched
);
  localparam int unsigned QUAL = qual_periods(MC_PERIODS, RST_MCS);

  pmode_e mode;
  logic   mc_last;
  logic   enter_pd;
  logic   wake_exit;

  rst_qualifier #(.QUAL(QUAL)) u_qual (
    .clk      (osc_clk),
    .rst_pin  (rst_pin),
    .core_rst (core_rst)
  );

  osc_divider #(.MC_PERIODS(MC_PERIODS)) u_div (
    .clk       (osc_clk),
    .rst       (core_rst),
    .phase_clk (phase_clk),
    .mc_last   (mc_last)
  );

  mode_fsm #(.IRQ_W(IRQ_W)) u_fsm (
    .clk       (osc_clk),
    .rst       (core_rst),
    .idle_wr   (idle_wr),
    .pd_wr     (pd_wr),
    .irq_req   (irq_req),
    .irq_en    (irq_en),
    .mc_last   (mc_last),
    .mode      (mode),
    .enter_pd  (enter_pd),
    .wake_exit (wake_exit)
  );

  always_ff @(posedge osc_clk) begin
    if (core_rst) ea_latched <= ea_strap;
  end

  assign cpu_clk_en = (mode == PM_RUN);
  assign per_clk_en = (mode != PM_DOWN);
  // The pin restarts a stopped oscillator so qualification can proceed.
  assign osc_run    = (mode != PM_DOWN) | rst_pin;
endmodule

// File: rtl/pwr_seq_chk.sv
`timescale 1ns/1ps
module pwr_seq_chk (
  input logic clk,
  input logic core_rst,
  input logic idle_wr,
  input logic pd_wr,
  input logic phase_clk,
  input logic cpu_clk_en,
  input logic per_clk_en,
  input logic ea_latched,
  input logic mc_last,
  input logic enter_pd,
  input logic wake_exit
);
  logic armed;
  always_ff @(posedge clk) begin
    if (core_rst) armed <= 1'b1;
  end

  // R1
  phase_toggle_chk: assert property (@(posedge clk) disable iff (core_rst || !armed)
    !$past(core_rst) |-> phase_clk != $past(phase_clk));

  // R5
  wake_align_chk: assert property (@(posedge clk) disable iff (core_rst || !armed)
    wake_exit |-> mc_last);

  // R5
  resume_align_chk: assert property (@(posedge clk) disable iff (core_rst || !armed)
    $rose(cpu_clk_en) && !$past(core_rst) |-> $past(mc_last));

  // R7
  pd_hold_chk: assert property (@(posedge clk) disable iff (core_rst || !armed)
    !per_clk_en |=> !cpu_clk_en && !per_clk_en);

  // R8
  pd_priority_chk: assert property (@(posedge clk) disable iff (core_rst || !armed)
    idle_wr && pd_wr && cpu_clk_en |-> enter_pd);

  // R10
  ea_hold_chk: assert property (@(posedge clk) disable iff (core_rst || !armed)
    !$past(core_rst) |-> $stable(ea_latched));
endmodule

bind pwr_seq_ctrl pwr_seq_chk u_chk (
  .clk        (osc_clk),
  .core_rst   (core_rst),
  .idle_wr    (idle_wr),
  .pd_wr      (pd_wr),
  .phase_clk  (phase_clk),
  .cpu_clk_en (cpu_clk_en),
  .per_clk_en (per_clk_en),
  .ea_latched (ea_latched),
  .mc_last    (mc_last),
  .enter_pd   (enter_pd),
  .wake_exit  (wake_exit)
);

// File: tb/test_pwr_seq_ctrl.sv
`timescale 1ns/1ps
module test_pwr_seq_ctrl;
  localparam int IRQ_W = 4;
  localparam int MC = 12;
  localparam int QUAL = 24;

  logic osc_clk = 1'b0;
  logic rst_pin = 1'b1;
  logic ea_strap = 1'b1;
  logic [IRQ_W-1:0] irq_req = '0;
  logic [IRQ_W-1:0] irq_en = '0;
  logic idle_wr = 1'b0;
  logic pd_wr = 1'b0;
  logic phase_clk, core_rst, cpu_clk_en, per_clk_en, osc_run, ea_latched;

  int tests = 0;
  int fails = 0;
  int cyc = 0;
  bit finished = 0;

  pwr_seq_ctrl #(.IRQ_W(IRQ_W)) i_pwr_seq_ctrl (
    .osc_clk, .rst_pin, .ea_strap, .irq_req, .irq_en, .idle_wr, .pd_wr,
    .phase_clk, .core_rst, .cpu_clk_en, .per_clk_en, .osc_run, .ea_latched
  );

  // Oscillator model: 200 MHz, stops while the block asks it to.
  always begin
    #2.5;
    if (osc_run) osc_clk = ~osc_clk;
  end
  always @(posedge osc_clk) cyc++;

  function automatic bit exp_reset(input int len);
    return len >= QUAL;
  endfunction
  function automatic bit exp_wake(input logic [IRQ_W-1:0] r, input logic [IRQ_W-1:0] e);
    return (r & e) != '0;
  endfunction

  task automatic check(input bit ok, input string req, input int act, input int exp);
    tests++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic tick(input int n);
    repeat (n) @(negedge osc_clk);
  endtask

  task automatic rst_pulse(input int len, output bit seen);
    @(negedge osc_clk);
    rst_pin = 1'b1;
    seen = 0;
    repeat (len) begin @(negedge osc_clk); seen |= core_rst; end
    rst_pin = 1'b0;
    repeat (5) begin @(negedge osc_clk); seen |= core_rst; end
  endtask

  task automatic enter_idle();
    @(negedge osc_clk);
    idle_wr = 1'b1;
    @(negedge osc_clk);
    idle_wr = 1'b0;
  endtask

  task automatic wait_wake(output int n);
    n = 0;
    while (!cpu_clk_en && n < 40) begin tick(1); n++; end
  endtask

  initial begin
    bit seen;
    int n, t1, t2;
    void'($urandom(32'd4242));

    // Reset state, strap capture, release timing
    tick(40);
    check(core_rst == 1, "R2 long reset", core_rst, 1);
    check(phase_clk == 0, "R1 phase held in reset", phase_clk, 0);
    check(ea_latched == 1, "R10 strap captured", ea_latched, 1);
    rst_pin = 1'b0;
    tick(2);
    check(core_rst == 1, "R3 still high after 2", core_rst, 1);
    tick(1);
    check(core_rst == 0, "R3 low after 3", core_rst, 0);
    check(cpu_clk_en && per_clk_en && osc_run, "R9 enables after reset",
          {cpu_clk_en, per_clk_en, osc_run}, 7);
    ea_strap = 1'b0;
    tick(5);
    check(ea_latched == 1, "R10 strap ignored", ea_latched, 1);

    // R1 toggling
    begin
      logic prev;
      bit ok;
      prev = phase_clk; ok = 1;
      for (int i = 0; i < 20; i++) begin
        tick(1);
        if (phase_clk == prev) ok = 0;
        prev = phase_clk;
      end
      check(ok, "R1 phase toggles", ok, 1);
    end

    // R2 boundaries and restart
    rst_pulse(23, seen);
    check(seen == 0, "R2 23 periods", seen, 0);
    rst_pulse(24, seen);
    check(seen == 1, "R2 24 periods", seen, 1);
    check(ea_latched == 0, "R10 strap recaptured", ea_latched, 0);
    @(negedge osc_clk); rst_pin = 1'b1; tick(20); rst_pin = 1'b0; tick(1);
    rst_pin = 1'b1; tick(20); rst_pin = 1'b0;
    seen = 0;
    repeat (6) begin tick(1); seen |= core_rst; end
    check(seen == 0, "R2 glitch restarts count", seen, 0);

    // R4 / R5 idle with wake, exit spacing
    enter_idle();
    check(!cpu_clk_en && per_clk_en && osc_run, "R4 idle enables",
          {cpu_clk_en, per_clk_en, osc_run}, 3);
    tick(7);
    irq_req = 4'b0100; irq_en = 4'b0110;
    wait_wake(n);
    t1 = cyc;
    check(n >= 1 && n <= MC, "R5 wake latency", n, MC);
    irq_req = '0; irq_en = '0;
    tick(3);
    enter_idle();
    tick(16);
    irq_req = 4'b0001; irq_en = 4'b0001;
    wait_wake(n);
    t2 = cyc;
    check(n >= 1 && n <= MC, "R5 wake latency 2", n, MC);
    check(((t2 - t1) % MC) == 0, "R5 exit on boundary", (t2 - t1) % MC, 0);
    irq_req = '0; irq_en = '0;

    // R6 masked, then R12 pd write in idle
    enter_idle();
    irq_req = 4'b1010; irq_en = 4'b0101;
    tick(30);
    check(cpu_clk_en == 0, "R6 masked no wake", cpu_clk_en, 0);
    @(negedge osc_clk); pd_wr = 1'b1; @(negedge osc_clk); pd_wr = 1'b0;
    tick(2);
    check(osc_run == 1 && per_clk_en == 1, "R12 pd write in idle ignored",
          {osc_run, per_clk_en}, 3);
    irq_en = 4'b1000;
    wait_wake(n);
    check(n >= 1 && n <= MC, "R5 wake after enabling", n, MC);
    irq_req = '0; irq_en = '0;

    // R11 pending at entry
    irq_req = 4'b0010; irq_en = 4'b0010;
    enter_idle();
    check(cpu_clk_en == 0, "R11 idle entered", cpu_clk_en, 0);
    wait_wake(n);
    check(n >= 1 && n <= MC, "R11 immediate exit", n, MC);
    irq_req = '0; irq_en = '0;

    // R7 power-down, interrupts ignored, R9 reset exit
    @(negedge osc_clk); pd_wr = 1'b1;
    @(posedge osc_clk); #1 pd_wr = 1'b0;
    #20;
    check(!osc_run && !per_clk_en && !cpu_clk_en, "R7 power-down",
          {osc_run, per_clk_en, cpu_clk_en}, 0);
    irq_req = 4'b1111; irq_en = 4'b1111;
    #200;
    check(!osc_run && !cpu_clk_en, "R7 irq ignored in power-down",
          {osc_run, cpu_clk_en}, 0);
    irq_req = '0; irq_en = '0;
    rst_pin = 1'b1;
    #1;
    check(osc_run == 1, "R9 pin restarts oscillator", osc_run, 1);
    tick(30);
    rst_pin = 1'b0;
    tick(4);
    check(cpu_clk_en && per_clk_en && osc_run, "R9 exit power-down",
          {cpu_clk_en, per_clk_en, osc_run}, 7);

    // R8 both strobes together
    @(negedge osc_clk); pd_wr = 1'b1; idle_wr = 1'b1;
    @(posedge osc_clk); #1 pd_wr = 1'b0; idle_wr = 1'b0;
    #20;
    check(!osc_run && !per_clk_en, "R8 power-down wins", {osc_run, per_clk_en}, 0);
    rst_pin = 1'b1; #1; tick(30); rst_pin = 1'b0; tick(4);
    check(cpu_clk_en == 1, "R9 exit after R8", cpu_clk_en, 1);

    // Random reset pulses
    for (int k = 0; k < 8; k++) begin
      int len;
      len = 10 + int'($urandom_range(30));
      rst_pulse(len, seen);
      check(seen == exp_reset(len), "R2 random pulse", seen, exp_reset(len));
    end

    // Random idle wake patterns
    for (int k = 0; k < 10; k++) begin
      logic [IRQ_W-1:0] r, e;
      bit w;
      r = IRQ_W'($urandom); e = IRQ_W'($urandom);
      w = exp_wake(r, e);
      enter_idle();
      tick(int'($urandom_range(11)));
      irq_req = r; irq_en = e;
      if (w) begin
        wait_wake(n);
        check(n >= 1 && n <= MC, "R5 random wake", n, MC);
      end else begin
        tick(30);
        check(cpu_clk_en == 0, "R6 random masked", cpu_clk_en, 0);
        rst_pulse(30, seen);
        check(cpu_clk_en == 1, "R9 reset ends idle", cpu_clk_en, 1);
      end
      irq_req = '0; irq_en = '0;
      tick(2);
    end

    finished = 1;
    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    #1_000_000;
    if (!finished) begin
      tests++; fails++;
      $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
      $display("  [TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end
endmodule